// File: doc/BRIEF.md
# Working Register File with Address Pointers

This block is the 32 x 8-bit working register store of a small 8-bit RISC core. Two read ports are combinational, so an operand pair is available in the same cycle it is named. One write port commits either a single byte or a 16-bit value into an even/odd register pair at the clock edge. The first read port also presents the aligned pair it falls in as a 16-bit operand.

The six highest registers double as three 16-bit address pointers. A pointer access selects one pointer and one addressing mode. The block returns the effective address and, where the mode calls for it, writes the adjusted pointer back in the same cycle. The register file also occupies the bottom of the data address space. An effective address below the register count therefore reads or stores a register rather than external memory, and the block resolves that hit itself.

Top module: `rf32_ptr_file`

## Requirements
- R1: While reset is asserted and right after it, every register reads as zero on both read ports.
- R2: `rd_a_data` and `rd_b_data` show the addressed registers combinationally and independently. A write lands at the rising clock edge, so a read of the register being written in that cycle still returns the old value.
- R3: An 8-bit write (`wr_en`=1, `wr_wide`=0) stores `wr_data[7:0]` into register `wr_idx` and leaves every other register unchanged.
- R4: A 16-bit write (`wr_wide`=1) to an even `wr_idx` stores `wr_data[7:0]` in that register and `wr_data[15:8]` in the next, odd register. `rd_a_wide` returns {odd, even} of the pair containing `rd_a_idx`; bit 0 of `rd_a_idx` is ignored for this output.
- R5: A 16-bit write to an odd index raises `wr_err` in the same cycle, and no register changes.
- R6: `ptr_sel` 0 selects the pointer in registers 26/27, 1 selects 28/29, and 2 or 3 selects 30/31. The even register holds the low byte.
- R7: `ptr_mode` 0 (plain) gives the pointer value as `eff_addr` and leaves the pointer unchanged.
- R8: `ptr_mode` 1 (post-increment) gives the old pointer as `eff_addr` and writes back pointer+1, modulo 2^16.
- R9: `ptr_mode` 2 (pre-decrement) writes back pointer-1, modulo 2^16, and uses that new value as `eff_addr`.
- R10: `ptr_mode` 3 (displacement) gives pointer + zero-extended 6-bit `ptr_disp` as `eff_addr` and leaves the pointer unchanged.
- R11: With `ptr_req`=1 and `eff_addr` below 0x0020, `win_hit` is 1 and `win_rdata` is the register numbered `eff_addr`. Otherwise `win_hit` and `win_rdata` are 0.
- R12: When `ptr_store`=1 and the window is hit, `ptr_wdata` is written into that register. A store that misses the window changes no register.
- R13: When several sources write the same register in one cycle, the pointer write-back wins over a window store, and a window store wins over the main write port.
- R14: With `ptr_req`=0, no pointer changes, whatever `ptr_mode` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A byte |
| rd_a_wide | output | 16 | Aligned pair around rd_a_idx, {odd, even} |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B byte |
| wr_en | input | 1 | Main write enable |
| wr_wide | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_idx | input | 5 | Main write destination |
| wr_data | input | 16 | Main write data (byte in bits 7:0) |
| wr_err | output | 1 | Wide write to an odd index, rejected |
| ptr_req | input | 1 | Pointer access this cycle |
| ptr_sel | input | 2 | Pointer choice |
| ptr_mode | input | 2 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_store | input | 1 | Access is a store |
| ptr_wdata | input | 8 | Store data |
| eff_addr | output | 16 | Effective data address |
| win_hit | output | 1 | Effective address falls in the register window |
| win_rdata | output | 8 | Register value at the hit address |

## Verification
Byte writes to scattered registers are read back on both ports, which separates the two read decoders. A read of a register in its own write cycle separates read-old from write-through behaviour. Pair writes at even and odd indices separate correct byte placement from rejection. Each pointer mode is run from ordinary values and from the 0x0000/0xFFFF wrap points, which distinguishes post- from pre-adjustment and adding from not adding the displacement. Window accesses are placed just inside and outside address 0x20. Stores are made to collide with a pointer's own register and with a main-port write, which exposes the write priority.

// File: rtl/rf32_pkg.sv
package rf32_pkg;
  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } ptr_mode_e;
endpackage

// File: rtl/rf32_ptr_unit.sv
module rf32_ptr_unit #(
  parameter int AW    = 16,
  parameter int DISPW = 6
) (
  input  logic [AW-1:0]    ptr_val,
  input  logic [1:0]       mode,
  input  logic [DISPW-1:0] disp,
  output logic [AW-1:0]    eff,
  output logic             wb_req,
  output logic [AW-1:0]    wb_val
);
  import rf32_pkg::*;
  ptr_mode_e m;
  always_comb begin
    m      = ptr_mode_e'(mode);
    eff    = ptr_val;
    wb_req = 1'b0;
    wb_val = ptr_val;
    unique case (m)
      PM_PLAIN: ;
      PM_POSTINC: begin
        wb_req = 1'b1;
        wb_val = ptr_val + AW'(1);
      end
      PM_PREDEC: begin
        wb_req = 1'b1;
        wb_val = ptr_val - AW'(1);
        eff    = wb_val;
      end
      PM_DISP: eff = ptr_val + AW'(disp);
      default: ;
    endcase
  end
endmodule

// File: rtl/rf32_window_decode.sv
module rf32_window_decode #(
  parameter int AW   = 16,
  parameter int IDXW = 5
) (
  input  logic            req,
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    hit = req && (addr[AW-1:IDXW] == '0);
    idx = addr[IDXW-1:0];
  end
endmodule

// File: rtl/rf32_write_select.sv
module rf32_write_select #(
  parameter int DW   = 8,
  parameter int IDXW = 5,
  parameter int CELL = 0
) (
  input  logic            main_en,
  input  logic            main_wide,
  input  logic [IDXW-1:0] main_idx,
  input  logic [2*DW-1:0] main_data,
  input  logic            st_en,
  input  logic [IDXW-1:0] st_idx,
  input  logic [DW-1:0]   st_data,
  input  logic            wb_en,
  input  logic [IDXW-1:0] wb_lo_idx,
  input  logic [2*DW-1:0] wb_data,
  output logic            cell_we,
  output logic [DW-1:0]   cell_d
);
  localparam logic [IDXW-1:0] MY_IDX = IDXW'(CELL);
  localparam bit              IS_ODD = (CELL % 2) == 1;

  logic main_hit, st_hit, wb_hit;
  always_comb begin
    main_hit = main_en && (main_wide ? (main_idx[IDXW-1:1] == MY_IDX[IDXW-1:1])
                                     : (main_idx == MY_IDX));
    st_hit   = st_en && (st_idx == MY_IDX);
    wb_hit   = wb_en && (wb_lo_idx[IDXW-1:1] == MY_IDX[IDXW-1:1]);
    cell_we  = main_hit || st_hit || wb_hit;
    if (wb_hit)
      cell_d = IS_ODD ? wb_data[2*DW-1:DW] : wb_data[DW-1:0];
    else if (st_hit)
      cell_d = st_data;
    else if (main_wide && IS_ODD)
      cell_d = main_data[2*DW-1:DW];
    else
      cell_d = main_data[DW-1:0];
  end
endmodule

// File: rtl/rf32_ptr_file.sv
module rf32_ptr_file #(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int DISPW    = 6,
  parameter int PTR_BASE = 26
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NREGS)-1:0]  rd_a_idx,
  output logic [DW-1:0]             rd_a_data,
  output logic [2*DW-1:0]           rd_a_wide,
  input  logic [$clog2(NREGS)-1:0]  rd_b_idx,
  output logic [DW-1:0]             rd_b_data,
  input  logic                      wr_en,
  input  logic                      wr_wide,
  input  logic [$clog2(NREGS)-1:0]  wr_idx,
  input  logic [2*DW-1:0]           wr_data,
  output logic                      wr_err,
  input  logic                      ptr_req,
  input  logic [1:0]                ptr_sel,
  input  logic [1:0]                ptr_mode,
  input  logic [DISPW-1:0]          ptr_disp,
  input  logic                      ptr_store,
  input  logic [DW-1:0]             ptr_wdata,
  output logic [AW-1:0]             eff_addr,
  output logic                      win_hit,
  output logic [DW-1:0]             win_rdata
);
  localparam int IDXW = $clog2(NREGS);

  logic [NREGS-1:0][DW-1:0] rf_q;
  logic [NREGS-1:0][DW-1:0] cell_d;
  logic [NREGS-1:0]         cell_we;

  // read side
  logic [IDXW-1:0] a_even, a_odd;
  always_comb begin
    a_even    = {rd_a_idx[IDXW-1:1], 1'b0};
    a_odd     = {rd_a_idx[IDXW-1:1], 1'b1};
    rd_a_data = rf_q[rd_a_idx];
    rd_b_data = rf_q[rd_b_idx];
    rd_a_wide = {rf_q[a_odd], rf_q[a_even]};
  end

  // main write qualification
  logic main_ok;
  always_comb begin
    wr_err  = wr_en && wr_wide && wr_idx[0];
    main_ok = wr_en && !wr_err;
  end

  // pointer selection
  logic [IDXW-1:0] ptr_lo, ptr_hi;
  logic [AW-1:0]   ptr_val;
  logic [1:0]      sel_eff;
  always_comb begin
    sel_eff = (ptr_sel == 2'd3) ? 2'd2 : ptr_sel;
    ptr_lo  = IDXW'(PTR_BASE) + IDXW'({sel_eff, 1'b0});
    ptr_hi  = ptr_lo | IDXW'(1);
    ptr_val = AW'({rf_q[ptr_hi], rf_q[ptr_lo]});
  end

  logic          unit_wb;
  logic [AW-1:0] unit_wb_val;
  rf32_ptr_unit #(.AW(AW), .DISPW(DISPW)) ptr_u (
    .ptr_val (ptr_val),
    .mode    (ptr_mode),
    .disp    (ptr_disp),
    .eff     (eff_addr),
    .wb_req  (unit_wb),
    .wb_val  (unit_wb_val)
  );

  logic [IDXW-1:0] win_idx;
  rf32_window_decode #(.AW(AW), .IDXW(IDXW)) win_u (
    .req  (ptr_req),
    .addr (eff_addr),
    .hit  (win_hit),
    .idx  (win_idx)
  );

  logic          st_en, wb_en;
  logic [2*DW-1:0] wb_pair;
  always_comb begin
    win_rdata = win_hit ? rf_q[win_idx] : '0;
    st_en     = win_hit && ptr_store;
    wb_en     = ptr_req && unit_wb;
    wb_pair   = unit_wb_val[2*DW-1:0];
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_cell
    rf32_write_select #(.DW(DW), .IDXW(IDXW), .CELL(i)) sel_u (
      .main_en   (main_ok),
      .main_wide (wr_wide),
      .main_idx  (wr_idx),
      .main_data (wr_data),
      .st_en     (st_en),
      .st_idx    (win_idx),
      .st_data   (ptr_wdata),
      .wb_en     (wb_en),
      .wb_lo_idx (ptr_lo),
      .wb_data   (wb_pair),
      .cell_we   (cell_we[i]),
      .cell_d    (cell_d[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++)
        if (cell_we[i]) rf_q[i] <= cell_d[i];
    end
  end
endmodule

// File: rtl/rf32_ptr_file_chk.sv
module rf32_ptr_file_chk #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int AW    = 16,
  parameter int DISPW = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(NREGS)-1:0] rd_a_idx,
  input logic [DW-1:0]            rd_a_data,
  input logic [$clog2(NREGS)-1:0] rd_b_idx,
  input logic [DW-1:0]            rd_b_data,
  input logic                     wr_en,
  input logic                     wr_wide,
  input logic [$clog2(NREGS)-1:0] wr_idx,
  input logic [2*DW-1:0]          wr_data,
  input logic                     wr_err,
  input logic                     ptr_req,
  input logic [1:0]               ptr_sel,
  input logic [1:0]               ptr_mode,
  input logic [AW-1:0]            eff_addr,
  input logic                     win_hit,
  input logic [DW-1:0]            win_rdata
);
  import rf32_pkg::*;
  localparam int IDXW = $clog2(NREGS);

  always @(negedge clk)
    if (!rst_n)
      assert_reset_zero_R1: assert (rd_a_data == '0 && rd_b_data == '0);

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide && !ptr_req && rd_a_idx == wr_idx)
    |=> (!$stable(rd_a_idx) || rd_a_data == $past(wr_data[DW-1:0])));

  assert_odd_wide_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !ptr_req && rd_a_idx == wr_idx)
    |=> (!$stable(rd_a_idx) || $stable(rd_a_data)));

  assert_postinc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_req && ptr_mode == PM_POSTINC && !wr_en)
    ##1 (ptr_req && ptr_mode == PM_PLAIN && $stable(ptr_sel))
    |-> eff_addr == $past(eff_addr) + AW'(1));

  assert_predec_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_req && ptr_mode == PM_PREDEC && !wr_en)
    ##1 (ptr_req && ptr_mode == PM_PLAIN && $stable(ptr_sel))
    |-> eff_addr == $past(eff_addr));

  assert_window_matches_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && rd_b_idx == eff_addr[IDXW-1:0]) |-> win_rdata == rd_b_data);
endmodule

bind rf32_ptr_file rf32_ptr_file_chk #(.NREGS(NREGS), .DW(DW), .AW(AW), .DISPW(DISPW)) chk_i (.*);

// File: tb/rf32_ptr_file_tb_top.sv
module rf32_ptr_file_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, ptr_wdata, win_rdata;
  logic [15:0] rd_a_wide, wr_data, eff_addr;
  logic        wr_en, wr_wide, wr_err, ptr_req, ptr_store, win_hit;
  logic [1:0]  ptr_sel, ptr_mode;
  logic [5:0]  ptr_disp;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rf32_ptr_file dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
    ptr_req = 0; ptr_sel = 0; ptr_mode = 0; ptr_disp = 0; ptr_store = 0; ptr_wdata = 0;
  endtask

  task automatic wr8(input logic [4:0] i, input logic [7:0] v);
    wr_en = 1; wr_wide = 0; wr_idx = i; wr_data = {8'h00, v};
    tick(); idle();
  endtask

  task automatic wr16(input logic [4:0] i, input logic [15:0] v);
    wr_en = 1; wr_wide = 1; wr_idx = i; wr_data = v;
    tick(); idle();
  endtask

  task automatic rd(input logic [4:0] i, output logic [7:0] v);
    rd_a_idx = i; #1; v = rd_a_data;
  endtask

  task automatic ptr_op(input logic [1:0] sel, input logic [1:0] mode, input logic [5:0] disp,
                        input logic st, input logic [7:0] wd,
                        output logic [15:0] ea, output logic hit, output logic [7:0] rdat);
    ptr_req = 1; ptr_sel = sel; ptr_mode = mode; ptr_disp = disp; ptr_store = st; ptr_wdata = wd;
    #1; ea = eff_addr; hit = win_hit; rdat = win_rdata;
    tick(); idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), v);
      check("R1 reset zero", 16'(v), 16'h0);
    end
  endtask

  task automatic t_byte();
    logic [7:0] v;
    wr8(5'd5, 8'hA5);
    wr8(5'd0, 8'h3C);
    rd_a_idx = 5'd5; rd_b_idx = 5'd0; #1;
    check("R2 port A", 16'(rd_a_data), 16'h00A5);
    check("R2 port B", 16'(rd_b_data), 16'h003C);
    rd(5'd6, v);
    check("R3 neighbour untouched", 16'(v), 16'h0);
  endtask

  task automatic t_read_old();
    logic [7:0] v;
    rd_a_idx = 5'd5;
    wr_en = 1; wr_idx = 5'd5; wr_data = 16'h0011; #1;
    check("R2 same-cycle read old", 16'(rd_a_data), 16'h00A5);
    tick(); idle();
    rd(5'd5, v);
    check("R2 value after edge", 16'(v), 16'h0011);
  endtask

  task automatic t_wide();
    logic [7:0] v;
    wr16(5'd24, 16'hBEEF);
    rd(5'd24, v); check("R4 low byte", 16'(v), 16'h00EF);
    rd(5'd25, v); check("R4 high byte", 16'(v), 16'h00BE);
    rd_a_idx = 5'd25; #1;
    check("R4 pair read odd idx", rd_a_wide, 16'hBEEF);
  endtask

  task automatic t_odd_wide();
    logic [7:0] v;
    wr8(5'd2, 8'h77);
    wr_en = 1; wr_wide = 1; wr_idx = 5'd3; wr_data = 16'h1234; #1;
    check("R5 wr_err flag", 16'(wr_err), 16'h1);
    tick(); idle();
    rd(5'd2, v); check("R5 r2 unchanged", 16'(v), 16'h0077);
    rd(5'd3, v); check("R5 r3 unchanged", 16'(v), 16'h0000);
  endtask

  task automatic t_plain_window();
    logic [15:0] ea; logic h; logic [7:0] d, v;
    wr8(5'd16, 8'h5A);
    wr16(5'd26, 16'h0010);
    ptr_op(2'd0, 2'd0, 6'd0, 1'b0, 8'h00, ea, h, d);
    check("R7 plain X eff", ea, 16'h0010);
    check("R11 hit", 16'(h), 16'h1);
    check("R11 window data", 16'(d), 16'h005A);
    rd(5'd26, v); check("R7 X unchanged", 16'(v), 16'h0010);
    ptr_op(2'd0, 2'd1, 6'd0, 1'b0, 8'h00, ea, h, d);
    rd_a_idx = 5'd0; mode_unused();
    ptr_mode = 2'd1; ptr_req = 0; tick(); idle();
    rd_a_idx = 5'd26; #1;
    check("R14 no update without req", rd_a_wide, 16'h0011);
  endtask

  task automatic mode_unused();
  endtask

  task automatic t_postinc();
    logic [15:0] ea; logic h; logic [7:0] d;
    wr16(5'd26, 16'h0010);
    ptr_op(2'd0, 2'd1, 6'd0, 1'b0, 8'h00, ea, h, d);
    check("R8 post-inc eff old", ea, 16'h0010);
    rd_a_idx = 5'd26; #1;
    check("R6 R8 X written back", rd_a_wide, 16'h0011);
    wr16(5'd28, 16'hFFFF);
    ptr_op(2'd1, 2'd1, 6'd0, 1'b0, 8'h00, ea, h, d);
    check("R8 Y eff at top", ea, 16'hFFFF);
    check("R11 no hit above window", 16'(h), 16'h0);
    rd_a_idx = 5'd28; #1;
    check("R8 Y wraps to zero", rd_a_wide, 16'h0000);
  endtask

  task automatic t_predec();
    logic [15:0] ea; logic h; logic [7:0] d;
    wr16(5'd30, 16'h0000);
    ptr_op(2'd2, 2'd2, 6'd0, 1'b0, 8'h00, ea, h, d);
    check("R9 pre-dec wrap eff", ea, 16'hFFFF);
    check("R11 miss data zero", 16'(d), 16'h0);
    rd_a_idx = 5'd30; #1;
    check("R9 Z written back", rd_a_wide, 16'hFFFF);
    wr16(5'd30, 16'h0006);
    ptr_op(2'd3, 2'd2, 6'd0, 1'b0, 8'h00, ea, h, d);
    check("R6 sel 3 is Z, R9 eff", ea, 16'h0005);
    check("R11 hit r5", 16'(d), 16'h0011);
  endtask

  task automatic t_disp();
    logic [15:0] ea; logic h; logic [7:0] d;
    wr16(5'd28, 16'h0100);
    ptr_op(2'd1, 2'd3, 6'd63, 1'b0, 8'h00, ea, h, d);
    check("R10 disp max", ea, 16'h013F);
    rd_a_idx = 5'd28; #1;
    check("R10 Y unchanged", rd_a_wide, 16'h0100);
    wr16(5'd28, 16'h0001);
    ptr_op(2'd1, 2'd3, 6'd31, 1'b0, 8'h00, ea, h, d);
    check("R11 edge addr 0x20 misses", 16'(h), 16'h0);
    ptr_op(2'd1, 2'd3, 6'd30, 1'b0, 8'h00, ea, h, d);
    check("R11 addr 0x1F hits", 16'(h), 16'h1);
    check("R11 addr 0x1F data", 16'(d), 16'h0);
  endtask

  task automatic t_store();
    logic [15:0] ea; logic h; logic [7:0] d, v;
    wr16(5'd30, 16'h0003);
    ptr_op(2'd2, 2'd0, 6'd0, 1'b1, 8'h99, ea, h, d);
    rd(5'd3, v); check("R12 store hit", 16'(v), 16'h0099);
    wr16(5'd30, 16'h0203);
    ptr_op(2'd2, 2'd0, 6'd0, 1'b1, 8'h44, ea, h, d);
    rd(5'd3, v); check("R12 store miss no change", 16'(v), 16'h0099);
  endtask

  task automatic t_priority();
    logic [15:0] ea; logic h; logic [7:0] d, v;
    wr16(5'd26, 16'h001A);
    wr_en = 1; wr_idx = 5'd26; wr_data = 16'h0044;
    ptr_op(2'd0, 2'd1, 6'd0, 1'b1, 8'hEE, ea, h, d);
    rd_a_idx = 5'd26; #1;
    check("R13 pointer writeback wins", rd_a_wide, 16'h001B);
    wr16(5'd30, 16'h0005);
    wr_en = 1; wr_idx = 5'd5; wr_data = 16'h0022;
    ptr_op(2'd2, 2'd0, 6'd0, 1'b1, 8'h66, ea, h, d);
    rd(5'd5, v); check("R13 store beats main port", 16'(v), 16'h0066);
  endtask

  initial begin
    idle(); rd_a_idx = 0; rd_b_idx = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_read_old();
    t_wide();
    t_odd_wide();
    t_plain_window();
    t_postinc();
    t_predec();
    t_disp();
    t_store();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule